// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit sits beside a two-wire serial bus controller core and turns the core's one-cycle event pulses into sticky status flags. Five of those flags (arbitration lost, missing acknowledge, access complete, receive byte ready, transmit slot ready) can raise a single interrupt request through a five-bit enable mask. Two error flags (receive overrun, transmit underflow) are recorded but never interrupt. The status word also shows a live bus-busy level.

Software clears flags by writing ones to them. It can also read a vector register that names the highest-priority event that is both pending and enabled. That read acknowledges the event, so a handler can loop on the vector register until it reads zero. The register port is a plain single-cycle strobe interface with a combinational read-data output.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0 apart from the live busy bit, the vector reads 0 and irq is low.
- R2: A one-cycle event pulse sets its sticky status bit on the next clock edge. The bit positions are: arbitration lost bit 0, no acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, transmit underflow bit 10, receive overrun bit 11.
- R3: A write to the status register clears each sticky bit where the write data holds a 1, and leaves each bit unchanged where the write data holds a 0.
- R4: When an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 12 follows the busBusy input with no delay, and writes to it have no effect. Status bits 5 to 9 and 13 to 15 always read 0.
- R6: The register offsets on addr are: enable 0, status 1, vector 2. The enable register holds bits 0 to 4, and its other bits read 0. Writes to the vector offset are ignored.
- R7: irq is high exactly while at least one of status bits 0 to 4 is set together with the matching enable bit.
- R8: The vector reads 0 when no enabled event is pending. Otherwise it reads the lowest code among the pending enabled events, where the codes are arbitration lost 1, no acknowledge 2, access ready 3, receive ready 4 and transmit ready 5. Pending events that are not enabled are not reported.
- R9: A read strobe (rdEn) at the vector offset returns the current code and clears only the status bit of the event reported. A vector read that returns 0 changes nothing.
- R10: The overrun and underflow flags never raise irq and never appear in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effect on the vector offset) |
| addr | input | ADDR_W | Register offset |
| wrData | input | REG_W | Write data |
| rdData | output | REG_W | Combinational read data for addr |
| evArbLost | input | 1 | Arbitration lost pulse |
| evNoAck | input | 1 | Missing acknowledge pulse |
| evAccRdy | input | 1 | Access complete pulse |
| evRxRdy | input | 1 | Receive byte ready pulse |
| evTxRdy | input | 1 | Transmit slot ready pulse |
| evRxOvr | input | 1 | Receive overrun pulse |
| evTxUdf | input | 1 | Transmit underflow pulse |
| busBusy | input | 1 | Live bus-busy level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: a 16-bit register word and a 2-bit offset. With these values all three registers and one unmapped offset can be reached. Every status bit position, including the reserved ones, is visible in one read. The five-entry priority chain can be driven through each of its orderings: pending but masked, several pending at once, and acknowledged by a vector read.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int IRQ_N    = 5;
  localparam int VEC_W    = $clog2(IRQ_N + 1);
  localparam int BIT_UDF  = 10;
  localparam int BIT_OVR  = 11;
  localparam int BIT_BUSY = 12;
  localparam int OFS_EN   = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_VEC  = 2;

  typedef enum logic [1:0] {SEL_EN, SEL_STAT, SEL_VEC, SEL_NONE} rdSel_e;

  typedef struct packed {
    logic   enWr;
    logic   statClr;
    logic   vecRd;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);
  logic hitEn, hitStat, hitVec;

  always_comb begin
    hitEn   = (addr == ADDR_W'(OFS_EN));
    hitStat = (addr == ADDR_W'(OFS_STAT));
    hitVec  = (addr == ADDR_W'(OFS_VEC));
    strb.enWr    = wrEn & hitEn;
    strb.statClr = wrEn & hitStat;
    strb.vecRd   = rdEn & hitVec;
    if (hitEn)        strb.rdSel = SEL_EN;
    else if (hitStat) strb.rdSel = SEL_STAT;
    else if (hitVec)  strb.rdSel = SEL_VEC;
    else              strb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [IRQ_N-1:0] evIrq,
  input  logic             evRxOvr,
  input  logic             evTxUdf,
  input  logic             busBusy,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] statusReg,
  output logic [IRQ_N-1:0] enableReg,
  output logic [VEC_W-1:0] vecCode,
  output logic             irq
);
  logic [IRQ_N-1:0] irqQ, enQ, pending, vecMask, w1cMask;
  logic             ovrQ, udfQ;

  assign pending = irqQ & enQ;
  assign irq     = |pending;

  // Priority: lowest index (lowest code) wins.
  always_comb begin
    vecCode = '0;
    for (int i = IRQ_N - 1; i >= 0; i--)
      if (pending[i]) vecCode = VEC_W'(i + 1);
  end

  always_comb begin
    for (int i = 0; i < IRQ_N; i++)
      vecMask[i] = strb.vecRd && (vecCode == VEC_W'(i + 1));
    w1cMask = strb.statClr ? wrData[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= '0;
      enQ  <= '0;
      ovrQ <= 1'b0;
      udfQ <= 1'b0;
    end else begin
      irqQ <= (irqQ & ~(w1cMask | vecMask)) | evIrq;
      ovrQ <= (ovrQ & ~(strb.statClr & wrData[BIT_OVR])) | evRxOvr;
      udfQ <= (udfQ & ~(strb.statClr & wrData[BIT_UDF])) | evTxUdf;
      if (strb.enWr) enQ <= wrData[IRQ_N-1:0];
    end
  end

  always_comb begin
    statusReg              = '0;
    statusReg[IRQ_N-1:0]   = irqQ;
    statusReg[BIT_UDF]     = udfQ;
    statusReg[BIT_OVR]     = ovrQ;
    statusReg[BIT_BUSY]    = busBusy;
  end

  assign enableReg = enQ;

  always_comb begin
    case (strb.rdSel)
      SEL_EN:   rdData = REG_W'(enQ);
      SEL_STAT: rdData = statusReg;
      SEL_VEC:  rdData = REG_W'(vecCode);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              evArbLost,
  input  logic              evNoAck,
  input  logic              evAccRdy,
  input  logic              evRxRdy,
  input  logic              evTxRdy,
  input  logic              evRxOvr,
  input  logic              evTxUdf,
  input  logic              busBusy,
  output logic              irq
);
  strobe_t          strb;
  logic [IRQ_N-1:0] evIrq;
  logic [REG_W-1:0] statusReg;
  logic [IRQ_N-1:0] enableReg;
  logic [VEC_W-1:0] vecCode;

  assign evIrq = {evTxRdy, evRxRdy, evAccRdy, evNoAck, evArbLost};

  isu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  isu_datapath #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .evIrq(evIrq),
    .evRxOvr(evRxOvr), .evTxUdf(evTxUdf), .busBusy(busBusy),
    .rdData(rdData), .statusReg(statusReg), .enableReg(enableReg),
    .vecCode(vecCode), .irq(irq)
  );
endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic              evArbLost,
  input logic              evNoAck,
  input logic              irq,
  input logic [REG_W-1:0]  statusReg,
  input logic [IRQ_N-1:0]  enableReg,
  input logic [VEC_W-1:0]  vecCode
);
  // R2 / R4: an event pulse always leaves its bit set, even against a clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> statusReg[0]);

  // R3: write-1 clears a bit when no event hits it
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_STAT) && wrData[1] && !evNoAck) |=> !statusReg[1]);

  // R7 / R8: irq and a non-zero vector go together
  a_r7_irq_vec: assert property (@(posedge clk) disable iff (!rstN)
    irq == (vecCode != '0));

  // R7: empty enable mask keeps irq low
  a_r7_masked: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |-> !irq);

  // R9: vector read acknowledges the reported event
  a_r9_vec_ack: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OFS_VEC) && vecCode == VEC_W'(1) && !evArbLost)
      |=> !statusReg[0]);

  // R5: reserved status bits stay zero
  a_r5_reserved: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[9:5] == '0 && statusReg[REG_W-1:13] == '0);
endmodule

bind irq_status_unit isu_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .evArbLost(evArbLost), .evNoAck(evNoAck), .irq(irq),
  .statusReg(statusReg), .enableReg(enableReg), .vecCode(vecCode)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  logic        clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wrData = 0, rdData;
  logic evArbLost = 0, evNoAck = 0, evAccRdy = 0, evRxRdy = 0, evTxRdy = 0;
  logic evRxOvr = 0, evTxUdf = 0, busBusy = 0, irq;
  int checks = 0, fails = 0;
  logic finished = 0;

  always #5 clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evArbLost(evArbLost), .evNoAck(evNoAck),
    .evAccRdy(evAccRdy), .evRxRdy(evRxRdy), .evTxRdy(evTxRdy),
    .evRxOvr(evRxOvr), .evTxUdf(evTxUdf), .busBusy(busBusy), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic rdVec(output logic [15:0] d);
    @(negedge clk); addr = 2; rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  // bit order: arb, nack, acc, rx, tx, ovr, udf
  task automatic pulse(logic [6:0] m);
    @(negedge clk);
    {evTxUdf, evRxOvr, evTxRdy, evRxRdy, evAccRdy, evNoAck, evArbLost} = m;
    @(negedge clk);
    {evTxUdf, evRxOvr, evTxRdy, evRxRdy, evAccRdy, evNoAck, evArbLost} = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(0, d); chk("R1 enable", d, 16'h0);
    rd(1, d); chk("R1 status", d, 16'h0);
    rd(2, d); chk("R1 vector", d, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_set;
    logic [15:0] d;
    pulse(7'b0000001); rd(1, d); chk("R2 arb bit0", d, 16'h0001);
    pulse(7'b1010000); rd(1, d); chk("R2 tx/udf", d, 16'h0411);
    pulse(7'b0101110); rd(1, d); chk("R2 sticky all", d, 16'h0C1F);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    wr(1, 16'h0000); rd(1, d); chk("R3 write zero", d, 16'h0C1F);
    wr(1, 16'h0400); rd(1, d); chk("R3 clear udf", d, 16'h081F);
    wr(1, 16'hFFFF); rd(1, d); chk("R3 clear all", d, 16'h0000);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    @(negedge clk); evNoAck = 1; wrEn = 1; addr = 1; wrData = 16'h0002;
    @(negedge clk); evNoAck = 0; wrEn = 0;
    rd(1, d); chk("R4 set wins", d, 16'h0002);
    wr(1, 16'h0002); rd(1, d); chk("R3 cleared after", d, 16'h0000);
  endtask

  task automatic t_busy_map;
    logic [15:0] d;
    @(negedge clk); busBusy = 1;
    rd(1, d); chk("R5 busy live", d, 16'h1000);
    wr(1, 16'hFFFF); rd(1, d); chk("R5 busy write ignored", d, 16'h1000);
    @(negedge clk); busBusy = 0;
    rd(1, d); chk("R5 busy falls", d, 16'h0000);
    wr(0, 16'hFFFF); rd(0, d); chk("R6 enable width", d, 16'h001F);
    wr(2, 16'hFFFF); rd(2, d); chk("R6 vector write ignored", d, 16'h0000);
    rd(3, d); chk("R6 unmapped reads 0", d, 16'h0000);
    wr(0, 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    pulse(7'b0001000); chk("R7 masked irq low", {15'b0, irq}, 16'h0);
    wr(0, 16'h0008); chk("R7 enabled irq high", {15'b0, irq}, 16'h1);
    wr(0, 16'h0010); chk("R7 other mask low", {15'b0, irq}, 16'h0);
    wr(1, 16'hFFFF); wr(0, 16'h001F);
    pulse(7'b1100000); chk("R10 errors no irq", {15'b0, irq}, 16'h0);
    rd(2, d); chk("R10 errors no vector", d, 16'h0000);
    wr(1, 16'hFFFF);
  endtask

  task automatic t_vec;
    logic [15:0] d;
    pulse(7'b0011010); rd(2, d); chk("R8 lowest code", d, 16'h0002);
    wr(0, 16'h001D); rd(2, d); chk("R8 masked skipped", d, 16'h0004);
    rdVec(d); chk("R9 read returns code", d, 16'h0004);
    rd(1, d); chk("R9 only reported cleared", d, 16'h0012);
    rd(2, d); chk("R8 next code", d, 16'h0005);
    wr(0, 16'h0000); rdVec(d); chk("R9 empty read", d, 16'h0000);
    rd(1, d); chk("R9 empty read no change", d, 16'h0012);
    wr(0, 16'h001F); rd(2, d); chk("R8 re-enabled", d, 16'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset;
    t_set;
    t_w1c;
    t_collide;
    t_busy_map;
    t_irq;
    t_vec;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule